// File: doc/BRIEF.md
# XMODEM-CRC Block Receiver

This engine receives a file sent with the XMODEM protocol over a byte-wide link, using the 16-bit CRC variant. Bytes from a serial receiver arrive on a valid/ready input. Protocol replies leave on a valid/ready output that feeds a serial transmitter. Payload bytes go to memory through a plain write port, with address, data and a strobe. Writing starts at a base address that is latched when the transfer starts.

A start pulse makes the engine ask the sender for CRC mode. It then checks every block's framing, sequence number and CRC in hardware. The first error of any kind ends the whole transfer: the engine sends no negative acknowledge and does not retry. When the transfer ends, the engine pulses `done_o`, reports success or failure, and reports how many payload bytes it accepted. A failed transfer always reports zero bytes, even though it may have left partial data in memory.

Top module: `xmodem_crc_rx`

## Requirements
- R1: A one-cycle `start_i` while the engine is idle latches `base_addr_i`, clears the reported length, and queues the CRC-mode request byte 0x43 as the first transmitted byte.
- R2: Where a block header is expected, 0x01 opens a block. The byte 0x04 in that position makes the engine transmit acknowledge 0x06 and then finish with `ok_o`=1.
- R3: Any other byte in the header position ends the transfer with `ok_o`=0 and `len_o`=0, and no further byte is transmitted.
- R4: The two bytes after 0x01 are a block number and its bitwise complement. If the two bytes do not XOR to 0xFF, the transfer fails as in R3. If the block number differs from the expected number, the transfer also fails as in R3.
- R5: The expected block number is 1 for the first block and increases by one, modulo 256, after each accepted block, so the 256th block is numbered 0.
- R6: Each block carries 128 data bytes. Each data byte is written one cycle after it is accepted, at address base + 128·(accepted blocks) + (byte index). The address rises by one between consecutive write cycles. A block that fails its CRC has already written all 128 of its bytes.
- R7: The CRC is polynomial 0x1021 with initial value 0x0000, processed most significant bit first over the 128 data bytes only. The received CRC arrives high byte first. On a match the engine transmits 0x06; on a mismatch the transfer fails as in R3.
- R8: After a successful transfer, `len_o` equals 128 times the number of accepted blocks.
- R9: `done_o` is high for exactly one cycle per transfer. Afterwards the engine is idle, and `ok_o` and `len_o` hold their values until the next start.
- R10: While idle, the engine accepts and discards input bytes. They produce no transmitted byte, no memory write and no `done_o`.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (honoured only when idle) |
| base_addr_i | input | AW | Memory address of the first payload byte |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte is present |
| rx_ready_o | output | 1 | Engine takes the received byte this cycle |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | Transmit byte is present |
| tx_ready_i | input | 1 | Transmitter takes the byte this cycle |
| wr_addr_o | output | AW | Memory write address |
| wr_data_o | output | 8 | Memory write data |
| wr_en_o | output | 1 | Memory write strobe |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| ok_o | output | 1 | Transfer finished successfully |
| len_o | output | LW | Payload bytes accepted in the transfer |

## Verification
Error-free transfers of random payloads, one to four blocks long, check the stored data, the written addresses, the acknowledge sequence and the final length. Each error type is injected by itself at a random block: a flipped CRC bit, a broken complement, a wrong block number and a foreign header byte. Each injection shows whether the engine stops at exactly that point, reports zero and has written the expected number of bytes. A 256-block transfer separates a correct modulo-256 sequence number from one that does not wrap to zero. Bytes sent before any start, and a transmitter that is stalled at random, show that idle input is discarded and that a pending reply byte is held.

// File: rtl/xmodem_rx_pkg.sv
package xmodem_rx_pkg;

    localparam logic [7:0] CODE_BLOCK_START = 8'h01;
    localparam logic [7:0] CODE_END         = 8'h04;
    localparam logic [7:0] CODE_ACK         = 8'h06;
    localparam logic [7:0] CODE_CRC_REQ     = 8'h43;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEND_REQ,
        ST_HEADER,
        ST_NUM,
        ST_NUM_INV,
        ST_PAYLOAD,
        ST_CHK_HI,
        ST_CHK_LO,
        ST_SEND_ACK,
        ST_SEND_FINAL
    } rx_state_e;

    // One byte through an MSB-first CRC shift register.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data,
                                               input logic [15:0] poly);
        logic [15:0] acc;
        acc = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (acc[15] ^ data[i])
                acc = {acc[14:0], 1'b0} ^ poly;
            else
                acc = {acc[14:0], 1'b0};
        end
        return acc;
    endfunction

endpackage

// File: rtl/xmodem_crc16.sv
module xmodem_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_i,
    input  logic        en_i,
    input  logic [7:0]  data_i,
    output logic [15:0] crc_o
);
    import xmodem_rx_pkg::*;

    typedef struct packed {
        logic [15:0] crc;
    } crc_reg_t;

    crc_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i)
            r_d.crc = INIT;
        else if (en_i)
            r_d.crc = crc16_byte(r_q.crc, data_i, POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '{crc: INIT};
        else
            r_q <= r_d;
    end

    assign crc_o = r_q.crc;

endmodule

// File: rtl/xmodem_tx_slot.sv
module xmodem_tx_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] byte_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         free_o
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.valid && ready_i)
            s_d.valid = 1'b0;
        if (push_i) begin
            s_d.valid = 1'b1;
            s_d.data  = byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign data_o  = s_q.data;
    assign free_o  = !s_q.valid;

endmodule

// File: rtl/xmodem_crc_rx.sv
module xmodem_crc_rx #(
    parameter int          AW        = 32,
    parameter int          LW        = 32,
    parameter int          BLK_BYTES = 128,
    parameter logic [15:0] CRC_POLY  = 16'h1021
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [7:0]    rx_data_i,
    input  logic          rx_valid_i,
    output logic          rx_ready_o,
    output logic [7:0]    tx_data_o,
    output logic          tx_valid_o,
    input  logic          tx_ready_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          wr_en_o,
    output logic          done_o,
    output logic          ok_o,
    output logic [LW-1:0] len_o
);
    import xmodem_rx_pkg::*;

    localparam int            CNT_W    = $clog2(BLK_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLK_BYTES - 1);

    typedef struct packed {
        rx_state_e        state;
        logic [7:0]       blk_exp;
        logic [7:0]       blk_num;
        logic [7:0]       chk_hi;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    blk_base;
        logic [LW-1:0]    len;
        logic             ok;
        logic             done;
        logic             wr_en;
        logic [AW-1:0]    wr_addr;
        logic [7:0]       wr_data;
    } eng_t;

    eng_t e_d, e_q;

    logic        take;
    logic        tx_push;
    logic [7:0]  tx_byte;
    logic        tx_free;
    logic        crc_clr;
    logic        crc_en;
    logic [15:0] crc_val;

    assign take = rx_valid_i && rx_ready_o;

    always_comb begin
        e_d        = e_q;
        e_d.done   = 1'b0;
        e_d.wr_en  = 1'b0;
        rx_ready_o = 1'b0;
        tx_push    = 1'b0;
        tx_byte    = 8'h00;
        crc_clr    = 1'b0;
        crc_en     = 1'b0;

        unique case (e_q.state)
            ST_IDLE: begin
                rx_ready_o = 1'b1;  // idle bytes are dropped
                if (start_i) begin
                    e_d.state    = ST_SEND_REQ;
                    e_d.blk_base = base_addr_i;
                    e_d.blk_exp  = 8'd1;
                    e_d.len      = '0;
                    e_d.ok       = 1'b0;
                end
            end
            ST_SEND_REQ: begin
                if (tx_free) begin
                    tx_push   = 1'b1;
                    tx_byte   = CODE_CRC_REQ;
                    e_d.state = ST_HEADER;
                end
            end
            ST_HEADER: begin
                rx_ready_o = 1'b1;
                if (take) begin
                    if (rx_data_i == CODE_BLOCK_START) begin
                        e_d.state = ST_NUM;
                        crc_clr   = 1'b1;
                    end else if (rx_data_i == CODE_END) begin
                        e_d.state = ST_SEND_FINAL;
                    end else begin
                        e_d.state = ST_IDLE;
                        e_d.done  = 1'b1;
                        e_d.ok    = 1'b0;
                        e_d.len   = '0;
                    end
                end
            end
            ST_NUM: begin
                rx_ready_o = 1'b1;
                if (take) begin
                    e_d.blk_num = rx_data_i;
                    e_d.state   = ST_NUM_INV;
                end
            end
            ST_NUM_INV: begin
                rx_ready_o = 1'b1;
                if (take) begin
                    if (((e_q.blk_num ^ rx_data_i) != 8'hFF) ||
                        (e_q.blk_num != e_q.blk_exp)) begin
                        e_d.state = ST_IDLE;
                        e_d.done  = 1'b1;
                        e_d.ok    = 1'b0;
                        e_d.len   = '0;
                    end else begin
                        e_d.state = ST_PAYLOAD;
                        e_d.cnt   = '0;
                    end
                end
            end
            ST_PAYLOAD: begin
                rx_ready_o = 1'b1;
                if (take) begin
                    crc_en      = 1'b1;
                    e_d.wr_en   = 1'b1;
                    e_d.wr_addr = e_q.blk_base + AW'(e_q.cnt);
                    e_d.wr_data = rx_data_i;
                    e_d.cnt     = e_q.cnt + 1'b1;
                    if (e_q.cnt == CNT_LAST)
                        e_d.state = ST_CHK_HI;
                end
            end
            ST_CHK_HI: begin
                rx_ready_o = 1'b1;
                if (take) begin
                    e_d.chk_hi = rx_data_i;
                    e_d.state  = ST_CHK_LO;
                end
            end
            ST_CHK_LO: begin
                rx_ready_o = 1'b1;
                if (take) begin
                    if ({e_q.chk_hi, rx_data_i} == crc_val) begin
                        e_d.state    = ST_SEND_ACK;
                        e_d.len      = e_q.len + LW'(BLK_BYTES);
                        e_d.blk_base = e_q.blk_base + AW'(BLK_BYTES);
                        e_d.blk_exp  = e_q.blk_exp + 8'd1;
                    end else begin
                        e_d.state = ST_IDLE;
                        e_d.done  = 1'b1;
                        e_d.ok    = 1'b0;
                        e_d.len   = '0;
                    end
                end
            end
            ST_SEND_ACK: begin
                if (tx_free) begin
                    tx_push   = 1'b1;
                    tx_byte   = CODE_ACK;
                    e_d.state = ST_HEADER;
                end
            end
            ST_SEND_FINAL: begin
                if (tx_free) begin
                    tx_push   = 1'b1;
                    tx_byte   = CODE_ACK;
                    e_d.state = ST_IDLE;
                    e_d.done  = 1'b1;
                    e_d.ok    = 1'b1;
                end
            end
            default: e_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    xmodem_crc16 #(
        .POLY (CRC_POLY),
        .INIT (16'h0000)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr),
        .en_i   (crc_en),
        .data_i (rx_data_i),
        .crc_o  (crc_val)
    );

    xmodem_tx_slot #(
        .W (8)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (tx_push),
        .byte_i  (tx_byte),
        .ready_i (tx_ready_i),
        .valid_o (tx_valid_o),
        .data_o  (tx_data_o),
        .free_o  (tx_free)
    );

    assign wr_en_o   = e_q.wr_en;
    assign wr_addr_o = e_q.wr_addr;
    assign wr_data_o = e_q.wr_data;
    assign done_o    = e_q.done;
    assign ok_o      = e_q.ok;
    assign len_o     = e_q.len;

endmodule

// File: rtl/xmodem_crc_rx_chk.sv
module xmodem_crc_rx_chk #(
    parameter int AW        = 32,
    parameter int LW        = 32,
    parameter int BLK_BYTES = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          tx_valid_o,
    input logic          tx_ready_i,
    input logic [7:0]    tx_data_o,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic          done_o,
    input logic          ok_o,
    input logic [LW-1:0] len_o
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(len_o) && $stable(ok_o))); // R9

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ok_o) |-> (len_o == '0)); // R3

    AST_LEN_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> ((len_o % LW'(BLK_BYTES)) == '0)); // R8

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (!wr_en_o || (wr_addr_o == $past(wr_addr_o) + AW'(1)))); // R6

endmodule

bind xmodem_crc_rx xmodem_crc_rx_chk #(
    .AW        (AW),
    .LW        (LW),
    .BLK_BYTES (BLK_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .len_o      (len_o)
);

// File: tb/xmodem_crc_rx_test.sv
`timescale 1ns/1ps
module xmodem_crc_rx_test;
    localparam int AW = 32;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [7:0]    rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [7:0]    tx_data;
    logic          tx_valid;
    logic          tx_ready = 1'b1;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_en;
    logic          done;
    logic          ok;
    logic [LW-1:0] len;

    always #4 clk = ~clk;

    xmodem_crc_rx #(.AW(AW), .LW(LW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_addr),
        .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
        .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_en_o(wr_en),
        .done_o(done), .ok_o(ok), .len_o(len)
    );

    int errors = 0;
    int checks = 0;

    // observation logs
    logic [7:0]    tx_log [0:511];
    int            tx_n = 0;
    logic [AW-1:0] got_addr [0:1023];
    logic [7:0]    got_data [0:1023];
    int            wr_n = 0;
    int            done_n = 0;
    int            hold_bad = 0;
    logic          prev_stall = 1'b0;
    logic [7:0]    prev_tx = '0;
    logic [7:0]    exp_data [0:1023];

    task automatic check(input bit cond, input string tag, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic top = r[15] ^ b[7-i];
            r = r << 1;
            if (top) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && !(tx_valid && tx_data == prev_tx)) hold_bad++;
            prev_stall = tx_valid && !tx_ready;
            prev_tx    = tx_data;
            if (tx_valid && tx_ready) begin
                if (tx_n < 512) tx_log[tx_n] = tx_data;
                tx_n++;
            end
            if (wr_en) begin
                if (wr_n < 1024) begin
                    got_addr[wr_n] = wr_addr;
                    got_data[wr_n] = wr_data;
                end
                wr_n++;
            end
            if (done) done_n++;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #2;
            tx_ready = ($urandom % 4) != 0;
        end
    end

    task automatic put(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic clear_logs();
        tx_n = 0; wr_n = 0; done_n = 0;
    endtask

    // fkind: 0 none, 1 crc, 2 complement, 3 wrong number, 4 bad header
    task automatic run_xfer(input int nblk, input int fkind, input int fblk, input bit check_mem);
        logic [15:0] crc;
        logic [7:0]  num, inv, d;
        int          exp_tx, exp_wr, exp_len;
        bit          exp_ok;
        int          wait_n;
        string       ftag;
        clear_logs();
        base_addr = $urandom;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= nblk; k++) begin
            if (fkind == 4 && k == fblk) begin
                put(8'h18);
                break;
            end
            put(8'h01);
            num = 8'(k);
            if (fkind == 3 && k == fblk) num = num + 8'd1;
            inv = ~num;
            if (fkind == 2 && k == fblk) inv = inv ^ 8'h10;
            put(num);
            put(inv);
            if ((fkind == 2 || fkind == 3) && k == fblk) break;
            crc = 16'h0000;
            for (int i = 0; i < 128; i++) begin
                d = 8'($urandom);
                if ((k - 1) * 128 + i < 1024) exp_data[(k-1)*128+i] = d;
                crc = ref_crc(crc, d);
                put(d);
            end
            if (fkind == 1 && k == fblk) crc = crc ^ (16'h0001 << ($urandom % 16));
            put(crc[15:8]);
            put(crc[7:0]);
            if (fkind == 1 && k == fblk) break;
        end
        if (fkind == 0) put(8'h04);
        wait_n = 0;
        while (done_n == 0 && wait_n < 3000) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (30) @(negedge clk);

        exp_ok  = (fkind == 0);
        exp_len = exp_ok ? nblk * 128 : 0;
        exp_tx  = exp_ok ? nblk + 2 : fblk;
        exp_wr  = exp_ok ? nblk * 128 : ((fkind == 1) ? fblk * 128 : (fblk - 1) * 128);
        ftag = (fkind == 0) ? "R2" : (fkind == 1) ? "R7" : (fkind == 4) ? "R3" : "R4";

        check(done_n == 1, "R9 one done pulse", done_n, 1);
        check(ok == exp_ok, {ftag, " ok status"}, ok, exp_ok);
        check(len == LW'(exp_len), "R8 reported length", len, exp_len);
        check(tx_n == exp_tx, {ftag, " R5 transmitted byte count"}, tx_n, exp_tx);
        if (tx_n > 0) check(tx_log[0] == 8'h43, "R1 first byte is CRC request", tx_log[0], 8'h43);
        begin
            int bad = 0;
            for (int i = 1; i < tx_n && i < 512; i++) if (tx_log[i] != 8'h06) bad++;
            check(bad == 0, "R7 replies are acknowledges", bad, 0);
        end
        check(wr_n == exp_wr, "R6 write count", wr_n, exp_wr);
        if (check_mem) begin
            int bad = 0;
            for (int i = 0; i < wr_n && i < 1024; i++) begin
                if (got_addr[i] != base_addr + AW'(i)) bad++;
                if (got_data[i] != exp_data[i]) bad++;
            end
            check(bad == 0, "R6 write address and data", bad, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R9 reset outputs quiet",
              {tx_valid, done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(len == '0 && ok == 1'b0, "R9 reset result cleared", len, 0);
        check(rx_ready == 1'b1, "R10 idle accepts input", rx_ready, 1);

        // idle bytes are discarded
        clear_logs();
        put(8'h01); put(8'h01); put(8'hFE); put(8'h04); put(8'h43);
        repeat (20) @(negedge clk);
        check(tx_n == 0, "R10 no transmit while idle", tx_n, 0);
        check(wr_n == 0, "R10 no write while idle", wr_n, 0);
        check(done_n == 0, "R10 no done while idle", done_n, 0);

        // directed cases
        run_xfer(0, 0, 0, 1'b0);      // immediate end
        run_xfer(3, 0, 0, 1'b1);      // clean transfer
        run_xfer(3, 1, 2, 1'b1);      // CRC error on block 2
        run_xfer(2, 2, 1, 1'b0);      // broken complement
        run_xfer(3, 3, 3, 1'b1);      // wrong block number
        run_xfer(2, 4, 2, 1'b1);      // foreign header byte
        run_xfer(1, 4, 1, 1'b0);      // foreign first header

        // random mix
        for (int t = 0; t < 6; t++) begin
            int nb = 1 + ($urandom % 4);
            int fk = $urandom % 5;
            int fb = 1 + ($urandom % nb);
            run_xfer(nb, fk, fk == 0 ? 0 : fb, 1'b1);
        end

        // sequence number wraps to zero on the 256th block
        run_xfer(256, 0, 0, 1'b0);
        check(len == LW'(32768), "R5 wrap transfer length", len, 32768);

        check(hold_bad == 0, "R11 stalled byte held", hold_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule